// File: doc/BRIEF.md
# Self-Synchronizing Serial Scrambler and Descrambler Pair

This block holds both ends of a serial data randomizer for a baseband link that moves one bit per period of a bit clock. The transmit channel mixes each incoming bit with its own output from five and seventeen bits before. The result is a line stream with no long runs and no DC bias. The receive channel mixes each line bit with the line bits received five and seventeen bits before. This undoes the transmit mixing. Because the receiver's memory is filled from the line itself, no seed or framing has to be aligned. Once seventeen line bits have arrived, the receiver tracks the transmitter on its own.

Each channel samples its bit clock input with the core clock. It takes a data bit on the chosen edge of the bit clock, rising or falling, but only when that channel's valid strobe is high. Data is registered on entry and registered again before it leaves. The transmit side can invert data before scrambling. The receive side can invert data after descrambling. With NRZ coding the two settings must match, so that the data is not inverted end to end.

Top module: `ssr_link_pair`

## Requirements
- R1: While reset is low, both history registers and both data outputs are cleared to 0. After reset, an all-zero input stream with no inversion gives an all-zero line stream.
- R2: The transmit output bit is y[n] = x'[n] XOR y[n-5] XOR y[n-17]. Here x' is the accepted input bit after optional inversion, and y bits before reset count as 0.
- R3: The receive output bit is z[n] = r[n] XOR r[n-5] XOR r[n-17], then optionally inverted. Here r is the accepted line bit, and r bits before reset count as 0.
- R4: With the transmit output fed to the receive input, the receiver reproduces the transmit input exactly once 17 line bits have been received, whatever it held before.
- R5: In that loop, one flipped line bit causes exactly three wrong output bits, at offsets 0, 5 and 17 from the flipped bit.
- R6: tx_invert = 1 complements each input bit before scrambling. With tx_invert = 0 the bit is used as is.
- R7: rx_invert = 1 complements each descrambled bit. Matched settings on the two sides give the original data back. Mismatched settings give its complement.
- R8: fall_edge = 0 takes the bit on a 0-to-1 transition of the bit clock. fall_edge = 1 takes it on a 1-to-0 transition. The other transition captures nothing.
- R9: An edge seen while the valid strobe is low is ignored. The history and the output stay unchanged.
- R10: The output changes on the 4th core clock rising edge after the selected bit clock edge reaches the pin (two synchronizer stages, one capture register, one output register). It holds its value between accepted bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples both bit clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_valid | input | 1 | Transmit bit valid strobe |
| tx_din | input | 1 | Transmit serial data in |
| tx_invert | input | 1 | 1 complements transmit data before scrambling |
| tx_fall_edge | input | 1 | 1 selects the falling edge of tx_bclk, 0 the rising edge |
| tx_dout | output | 1 | Scrambled line bit |
| rx_bclk | input | 1 | Receive bit clock |
| rx_valid | input | 1 | Receive bit valid strobe |
| rx_din | input | 1 | Received line bit |
| rx_invert | input | 1 | 1 complements descrambled data |
| rx_fall_edge | input | 1 | 1 selects the falling edge of rx_bclk, 0 the rising edge |
| rx_dout | output | 1 | Descrambled data out |

## Verification
The assertions assume that a bit clock never toggles faster than every core cycle. They also assume that data, valid and the polarity inputs stay steady from a selected edge until the capture register has taken them. The stimulus holds each bit clock level for six core cycles. It changes data only at falling core edges, well away from any capture, and changes the polarity settings only between runs that begin with a reset. The split-period edge test changes data between the two bit clock edges, and only after the first edge's capture has finished.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

   typedef enum logic {
      SSR_SCRAMBLE   = 1'b0,
      SSR_DESCRAMBLE = 1'b1
   } ssr_mode_e;

   localparam int unsigned SSR_TAP_NEAR_DEF = 5;
   localparam int unsigned SSR_TAP_FAR_DEF  = 17;
   localparam int unsigned SSR_SYNC_DEF     = 2;
   localparam int unsigned SSR_SYNC_MAX     = 4;

   // three-term modulo-2 sum used by both directions
   function automatic logic ssr_mix(input logic cur, input logic near_b, input logic far_b);
      return cur ^ near_b ^ far_b;
   endfunction

endpackage

// File: rtl/ssr_hist.sv
module ssr_hist #(
   parameter int unsigned TAP_NEAR = ssr_pkg::SSR_TAP_NEAR_DEF,
   parameter int unsigned TAP_FAR  = ssr_pkg::SSR_TAP_FAR_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_en,
   input  logic shift_in,
   output logic tap_near,
   output logic tap_far,
   output logic newest
);
   localparam int unsigned LEN = TAP_FAR;

   generate
      if (TAP_NEAR < 1 || TAP_NEAR >= TAP_FAR) begin : g_bad_taps
         $error("ssr_hist: TAP_NEAR must be in 1..TAP_FAR-1");
      end
   endgenerate

   logic [LEN-1:0] hist;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= '0;
      end else if (shift_en) begin
         hist <= {hist[LEN-2:0], shift_in};
      end
   end

   assign tap_near = hist[TAP_NEAR-1];
   assign tap_far  = hist[LEN-1];
   assign newest   = hist[0];

   assert_hist_clear_R1: assert property (@(posedge clk) !rst_n |=> (hist == '0));

   assert_hist_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(hist));

   assert_hist_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (hist[1] == $past(hist[0])));

endmodule

// File: rtl/ssr_bit_strobe.sv
module ssr_bit_strobe #(
   parameter int unsigned SYNC_STAGES = ssr_pkg::SSR_SYNC_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk,
   input  logic valid,
   input  logic fall_sel,
   output logic step
);
   logic bsync;
   logic prev;
   logic rise_seen;
   logic fall_seen;

   generate
      if (SYNC_STAGES > ssr_pkg::SSR_SYNC_MAX) begin : g_bad_sync
         $error("ssr_bit_strobe: SYNC_STAGES too large");
      end

      if (SYNC_STAGES == 0) begin : g_direct
         assign bsync = bclk;
      end else if (SYNC_STAGES == 1) begin : g_one
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= bclk;
         end
         assign bsync = stage_q;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], bclk};
         end
         assign bsync = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= bsync;
   end

   assign rise_seen = bsync & ~prev;
   assign fall_seen = ~bsync & prev;
   assign step      = valid & (fall_sel ? fall_seen : rise_seen);

   assert_single_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> !step);

endmodule

// File: rtl/ssr_channel.sv
module ssr_channel #(
   parameter ssr_pkg::ssr_mode_e MODE        = ssr_pkg::SSR_SCRAMBLE,
   parameter int unsigned        TAP_NEAR    = ssr_pkg::SSR_TAP_NEAR_DEF,
   parameter int unsigned        TAP_FAR     = ssr_pkg::SSR_TAP_FAR_DEF,
   parameter int unsigned        SYNC_STAGES = ssr_pkg::SSR_SYNC_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk,
   input  logic valid,
   input  logic din,
   input  logic invert,
   input  logic fall_sel,
   output logic dout
);
   logic step;
   logic in_next;
   logic in_q;
   logic pend;
   logic mixed;
   logic shift_in;
   logic tap_near;
   logic tap_far;
   logic newest;
   logic dout_q;

   ssr_bit_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk     (bclk),
      .valid    (valid),
      .fall_sel (fall_sel),
      .step     (step)
   );

   ssr_hist #(.TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (pend),
      .shift_in (shift_in),
      .tap_near (tap_near),
      .tap_far  (tap_far),
      .newest   (newest)
   );

   generate
      if (MODE == ssr_pkg::SSR_SCRAMBLE) begin : g_scr
         // polarity applied on entry, memory fed from own output
         assign in_next  = din ^ invert;
         assign mixed    = ssr_pkg::ssr_mix(in_q, tap_near, tap_far);
         assign shift_in = mixed;

         assert_feedback_R2: assert property (@(posedge clk) disable iff (!rst_n)
            pend |=> (newest == dout_q));
      end else begin : g_dscr
         // memory fed from the line, polarity applied on exit
         assign in_next  = din;
         assign mixed    = ssr_pkg::ssr_mix(in_q, tap_near, tap_far) ^ invert;
         assign shift_in = in_q;

         assert_feedback_R3: assert property (@(posedge clk) disable iff (!rst_n)
            pend |=> (newest == $past(in_q)));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q   <= 1'b0;
         pend   <= 1'b0;
         dout_q <= 1'b0;
      end else begin
         pend <= step;
         if (step) in_q   <= in_next;
         if (pend) dout_q <= mixed;
      end
   end

   assign dout = dout_q;

   assert_out_clear_R1: assert property (@(posedge clk) !rst_n |=> (dout_q == 1'b0));

   assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pend |=> $stable(dout_q));

   assert_capture_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(in_q));

endmodule

// File: rtl/ssr_link_pair.sv
module ssr_link_pair #(
   parameter int unsigned TAP_NEAR    = ssr_pkg::SSR_TAP_NEAR_DEF,
   parameter int unsigned TAP_FAR     = ssr_pkg::SSR_TAP_FAR_DEF,
   parameter int unsigned SYNC_STAGES = ssr_pkg::SSR_SYNC_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_bclk,
   input  logic tx_valid,
   input  logic tx_din,
   input  logic tx_invert,
   input  logic tx_fall_edge,
   output logic tx_dout,
   input  logic rx_bclk,
   input  logic rx_valid,
   input  logic rx_din,
   input  logic rx_invert,
   input  logic rx_fall_edge,
   output logic rx_dout
);

   ssr_channel #(
      .MODE        (ssr_pkg::SSR_SCRAMBLE),
      .TAP_NEAR    (TAP_NEAR),
      .TAP_FAR     (TAP_FAR),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk     (tx_bclk),
      .valid    (tx_valid),
      .din      (tx_din),
      .invert   (tx_invert),
      .fall_sel (tx_fall_edge),
      .dout     (tx_dout)
   );

   ssr_channel #(
      .MODE        (ssr_pkg::SSR_DESCRAMBLE),
      .TAP_NEAR    (TAP_NEAR),
      .TAP_FAR     (TAP_FAR),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk     (rx_bclk),
      .valid    (rx_valid),
      .din      (rx_din),
      .invert   (rx_invert),
      .fall_sel (rx_fall_edge),
      .dout     (rx_dout)
   );

endmodule

// File: tb/ssr_link_pair_tb.sv
module ssr_link_pair_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_bclk = 1'b0, tx_valid = 1'b0, tx_din = 1'b0, tx_invert = 1'b0, tx_fall_edge = 1'b0;
   logic rx_bclk = 1'b0, rx_valid = 1'b0, rx_din = 1'b0, rx_invert = 1'b0, rx_fall_edge = 1'b0;
   logic tx_dout, rx_dout;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [16:0] m_tx_h, m_rx_h;
   logic exp_tx, exp_rx;

   always #10 clk = ~clk;

   ssr_link_pair u_dut (
      .clk(clk), .rst_n(rst_n),
      .tx_bclk(tx_bclk), .tx_valid(tx_valid), .tx_din(tx_din),
      .tx_invert(tx_invert), .tx_fall_edge(tx_fall_edge), .tx_dout(tx_dout),
      .rx_bclk(rx_bclk), .rx_valid(rx_valid), .rx_din(rx_din),
      .rx_invert(rx_invert), .rx_fall_edge(rx_fall_edge), .rx_dout(rx_dout)
   );

   task automatic check(input logic got, input logic exp, input string req, input string what);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, got, exp);
      end
   endtask

   task automatic model_tx(input logic d);
      logic o;
      o = (d ^ tx_invert) ^ m_tx_h[4] ^ m_tx_h[16];
      m_tx_h = {m_tx_h[15:0], o};
      exp_tx = o;
   endtask

   task automatic model_rx(input logic l);
      logic o;
      o = l ^ m_rx_h[4] ^ m_rx_h[16] ^ rx_invert;
      m_rx_h = {m_rx_h[15:0], l};
      exp_rx = o;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tx_bclk = 1'b0; rx_bclk = 1'b0; tx_valid = 1'b0; rx_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_tx_h = '0; m_rx_h = '0; exp_tx = 1'b0; exp_rx = 1'b0;
      @(negedge clk);
   endtask

   // one bit period: both edges of both bit clocks, same data throughout
   task automatic bit_period(input logic td, input logic tv, input logic rd, input logic rv);
      tx_din = td; tx_valid = tv; rx_din = rd; rx_valid = rv;
      tx_bclk = 1'b1; rx_bclk = 1'b1;
      repeat (6) @(negedge clk);
      tx_bclk = 1'b0; rx_bclk = 1'b0;
      repeat (6) @(negedge clk);
      if (tv) model_tx(td);
      if (rv) model_rx(rd);
   endtask

   // data a before the rising edge, data b before the falling edge
   task automatic split_period(input logic a, input logic b, input logic ra, input logic rb);
      tx_din = a; rx_din = ra; tx_valid = 1'b1; rx_valid = 1'b1;
      tx_bclk = 1'b1; rx_bclk = 1'b1;
      repeat (6) @(negedge clk);
      tx_din = b; rx_din = rb;
      tx_bclk = 1'b0; rx_bclk = 1'b0;
      repeat (6) @(negedge clk);
      model_tx(tx_fall_edge ? b : a);
      model_rx(rx_fall_edge ? rb : ra);
   endtask

   task automatic t_reset();
      do_reset();
      tx_invert = 1'b0; rx_invert = 1'b0; tx_fall_edge = 1'b0; rx_fall_edge = 1'b0;
      check(tx_dout, 1'b0, "R1", "tx_dout after reset");
      check(rx_dout, 1'b0, "R1", "rx_dout after reset");
   endtask

   task automatic t_zero();
      do_reset();
      for (int i = 0; i < 20; i++) begin
         bit_period(1'b0, 1'b1, 1'b0, 1'b1);
         check(tx_dout, 1'b0, "R1", "tx zero stream");
         check(rx_dout, 1'b0, "R1", "rx zero stream");
      end
   endtask

   task automatic t_random();
      do_reset();
      for (int i = 0; i < 40; i++) begin
         bit_period(1'($urandom), 1'b1, 1'($urandom), 1'b1);
         check(tx_dout, exp_tx, "R2", "scrambler equation");
         check(rx_dout, exp_rx, "R3", "descrambler equation");
      end
   endtask

   task automatic t_invert();
      tx_invert = 1'b1; rx_invert = 1'b1;
      do_reset();
      bit_period(1'b0, 1'b1, 1'b0, 1'b1);
      check(tx_dout, 1'b1, "R6", "inverted zero first bit");
      check(rx_dout, 1'b1, "R7", "inverted rx zero first bit");
      for (int i = 0; i < 30; i++) begin
         bit_period(1'($urandom), 1'b1, 1'($urandom), 1'b1);
         check(tx_dout, exp_tx, "R6", "tx inverted stream");
         check(rx_dout, exp_rx, "R7", "rx inverted stream");
      end
      tx_invert = 1'b0; rx_invert = 1'b0;
   endtask

   task automatic t_edge();
      for (int s = 0; s < 2; s++) begin
         tx_fall_edge = (s == 0); rx_fall_edge = (s == 0);
         do_reset();
         for (int i = 0; i < 20; i++) begin
            logic a, ra;
            a = 1'($urandom); ra = 1'($urandom);
            split_period(a, ~a, ra, ~ra);
            check(tx_dout, exp_tx, "R8", "tx edge select");
            check(rx_dout, exp_rx, "R8", "rx edge select");
         end
      end
      tx_fall_edge = 1'b0; rx_fall_edge = 1'b0;
   endtask

   task automatic t_valid();
      do_reset();
      for (int i = 0; i < 40; i++) begin
         logic v;
         v = (i % 3 == 1) ? 1'b0 : 1'($urandom);
         bit_period(1'($urandom), v, 1'($urandom), v);
         check(tx_dout, exp_tx, "R9", "tx gated by valid");
         check(rx_dout, exp_rx, "R9", "rx gated by valid");
      end
   endtask

   task automatic t_latency();
      do_reset();
      for (int i = 0; i < 4; i++) begin
         logic d, old_v;
         old_v = exp_tx;
         d = ~old_v ^ m_tx_h[4] ^ m_tx_h[16] ^ tx_invert;
         tx_din = d; tx_valid = 1'b1; rx_valid = 1'b0;
         tx_bclk = 1'b1;
         repeat (3) @(negedge clk);
         check(tx_dout, old_v, "R10", "output before 4th edge");
         @(negedge clk);
         check(tx_dout, ~old_v, "R10", "output at 4th edge");
         repeat (2) @(negedge clk);
         tx_bclk = 1'b0;
         repeat (6) @(negedge clk);
         model_tx(d);
         check(tx_dout, exp_tx, "R10", "output held");
      end
   endtask

   task automatic t_loop(input logic tinv, input logic rinv, input int err_at, input string req);
      logic data_q [0:63];
      logic line_prev;
      int   n_err;
      int   n_wrong;
      tx_invert = tinv; rx_invert = rinv;
      do_reset();
      line_prev = 1'b0;
      n_err = 0;
      n_wrong = 0;
      for (int k = 0; k < 60; k++) begin
         logic d, lb;
         d = 1'($urandom);
         data_q[k] = d;
         lb = (k - 1 == err_at) ? ~line_prev : line_prev;
         bit_period(d, 1'b1, lb, (k > 0));
         if (k >= 18) begin
            logic want;
            want = data_q[k-1] ^ (tinv ^ rinv);
            if (err_at < 0) begin
               check(rx_dout, want, req, "loopback data");
            end else begin
               int off;
               logic bad_pos;
               off = (k - 1) - err_at;
               bad_pos = (off == 0) || (off == 5) || (off == 17);
               if (rx_dout !== want) n_err++;
               if ((rx_dout !== want) != bad_pos) n_wrong++;
            end
         end
         line_prev = tx_dout;
      end
      if (err_at >= 0) begin
         check(n_err == 3, 1'b1, "R5", $sformatf("error count %0d", n_err));
         check(n_wrong == 0, 1'b1, "R5", $sformatf("misplaced errors %0d", n_wrong));
      end
      tx_invert = 1'b0; rx_invert = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h5A17));
      t_reset();
      t_zero();
      t_random();
      t_invert();
      t_edge();
      t_valid();
      t_latency();
      t_loop(1'b0, 1'b0, -1, "R4");
      t_loop(1'b1, 1'b1, -1, "R7");
      t_loop(1'b1, 1'b0, -1, "R7");
      t_loop(1'b0, 1'b0, 25, "R5");
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule